// File: doc/BRIEF.md
# Integer/Fractional Feedback Clock Divider

This block sits in the feedback path of a clock synthesizer. It counts cycles of a fast input clock and emits a single-cycle pulse once per division period. In integer mode the period is a whole number of input cycles. In fractional mode a 16-bit accumulator gains the fraction word once per period. The period grows by one cycle whenever that addition carries out of 16 bits, so the long-run ratio is N + F/65536.

A new setting (mode, integer part, fraction) is offered with a one-cycle load strobe. A legal setting is parked and takes effect at the next period boundary. The period that is in progress always finishes at its old length. A setting that is illegal for the chosen mode raises an error flag, and the divider keeps running on its last good setting.

Top module: `fb_clock_divider`

## Requirements
- R1: With the mode input low (integer mode), any ratio N from 2 to 66 inclusive is accepted. Every output period is then exactly N input cycles.
- R2: With the mode input high (fractional mode), any integer part N from 8 to 66 inclusive is accepted.
- R3: In fractional mode each period adds the 16-bit fraction F to a 16-bit accumulator. The period is N+1 cycles when the sum carries past bit 15 and N cycles otherwise. The accumulator restarts from zero when a setting takes effect, so K periods last K*N + floor(K*F/65536) cycles.
- R4: In fractional mode with F = 0, every period is exactly N cycles.
- R5: A load whose ratio is outside the range for its mode sets the error flag in the next cycle. The setting then in use keeps running unchanged, and the flag holds its value in cycles without a load.
- R6: A load with a legal ratio clears the error flag in the next cycle.
- R7: A setting loaded during a period takes effect at the next period boundary. The period in progress completes at its old length.
- R8: While reset is low, the pulse output and the error flag are low. After release, the divider runs in integer mode with ratio 2. The first pulse appears two cycles after release.
- R9: The output pulse is high for exactly one input cycle per period.
- R10: In integer mode the fraction word has no effect: the period stays exactly N even when F is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| frac_mode | input | 1 | 0 = integer mode, 1 = fractional mode; taken with load |
| ratio | input | 7 | Integer ratio N; taken with load |
| frac | input | 16 | Fraction word F in units of 1/65536; taken with load |
| load | input | 1 | One-cycle strobe that offers a new setting |
| div_pulse | output | 1 | One-cycle pulse per division period |
| cfg_err | output | 1 | Set by an illegal load, cleared by a legal one |

## Verification
The assertions assume that load is a synchronous strobe and that ratio and frac_mode are settled whenever load is high. They also assume the ratio stays within its 7-bit field, so every period the checker sees lies between 2 and 67 cycles. The stimulus changes inputs only on falling clock edges and raises load only in the first cycle of a period. A load therefore never lands on a period boundary, and the first interval after each load can be predicted as the old length. The bench sweeps every legal integer ratio and a grid of fractional settings, and computes each expected period and each total duration arithmetically.

// File: rtl/fbdiv_pkg.sv
`timescale 1ns/1ps
package fbdiv_pkg;
    localparam int unsigned RATIO_W = 7;
    localparam int unsigned FRAC_W  = 16;

    typedef struct packed {
        logic               frac_mode;
        logic [RATIO_W-1:0] ratio;
        logic [FRAC_W-1:0]  frac;
    } div_cfg_t;

    typedef struct packed {
        div_cfg_t           act;
        div_cfg_t           pend;
        logic               pend_vld;
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] len;
        logic [FRAC_W-1:0]  acc;
        logic               pulse;
        logic               err;
    } div_state_t;
endpackage

// File: rtl/fbdiv_range_check.sv
`timescale 1ns/1ps
module fbdiv_range_check import fbdiv_pkg::*; #(
    parameter int unsigned INT_LO  = 2,
    parameter int unsigned INT_HI  = 66,
    parameter int unsigned FRAC_LO = 8,
    parameter int unsigned FRAC_HI = 66
) (
    input  logic               frac_mode,
    input  logic [RATIO_W-1:0] ratio,
    output logic               legal
);
    localparam logic [RATIO_W-1:0] I_LO = RATIO_W'(INT_LO);
    localparam logic [RATIO_W-1:0] I_HI = RATIO_W'(INT_HI);
    localparam logic [RATIO_W-1:0] F_LO = RATIO_W'(FRAC_LO);
    localparam logic [RATIO_W-1:0] F_HI = RATIO_W'(FRAC_HI);

    always_comb begin
        if (frac_mode) legal = (ratio >= F_LO) && (ratio <= F_HI);
        else           legal = (ratio >= I_LO) && (ratio <= I_HI);
    end
endmodule

// File: rtl/fbdiv_frac_step.sv
`timescale 1ns/1ps
module fbdiv_frac_step #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] inc,
    output logic [W-1:0] sum,
    output logic         carry
);
    always_comb {carry, sum} = {1'b0, base} + {1'b0, inc};
endmodule

// File: rtl/fb_clock_divider.sv
`timescale 1ns/1ps
module fb_clock_divider import fbdiv_pkg::*; #(
    parameter int unsigned INT_LO  = 2,
    parameter int unsigned INT_HI  = 66,
    parameter int unsigned FRAC_LO = 8,
    parameter int unsigned FRAC_HI = 66
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frac_mode,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [FRAC_W-1:0]  frac,
    input  logic               load,
    output logic               div_pulse,
    output logic               cfg_err
);
    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    div_state_t         r_q, r_d;
    div_cfg_t           nxt_cfg;
    logic               cfg_legal;
    logic               wrap;
    logic [FRAC_W-1:0]  acc_base;
    logic [FRAC_W-1:0]  acc_sum;
    logic               acc_carry;

    fbdiv_range_check #(
        .INT_LO(INT_LO), .INT_HI(INT_HI), .FRAC_LO(FRAC_LO), .FRAC_HI(FRAC_HI)
    ) u_range (
        .frac_mode(frac_mode),
        .ratio    (ratio),
        .legal    (cfg_legal)
    );

    // setting for the period that starts at the next boundary
    always_comb begin
        nxt_cfg  = r_q.pend_vld ? r_q.pend : r_q.act;
        acc_base = r_q.pend_vld ? '0 : r_q.acc;
        wrap     = (r_q.cnt == r_q.len - ONE);
    end

    fbdiv_frac_step #(.W(FRAC_W)) u_step (
        .base (acc_base),
        .inc  (nxt_cfg.frac),
        .sum  (acc_sum),
        .carry(acc_carry)
    );

    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        if (wrap) begin
            r_d.cnt      = '0;
            r_d.pulse    = 1'b1;
            r_d.act      = nxt_cfg;
            r_d.pend_vld = 1'b0;
            if (nxt_cfg.frac_mode) begin
                r_d.acc = acc_sum;
                r_d.len = nxt_cfg.ratio + {{(RATIO_W-1){1'b0}}, acc_carry};
            end else begin
                r_d.acc = '0;
                r_d.len = nxt_cfg.ratio;
            end
        end else begin
            r_d.cnt = r_q.cnt + ONE;
        end
        // a load in a boundary cycle parks for the following boundary
        if (load) begin
            if (cfg_legal) begin
                r_d.pend.frac_mode = frac_mode;
                r_d.pend.ratio     = ratio;
                r_d.pend.frac      = frac;
                r_d.pend_vld       = 1'b1;
                r_d.err            = 1'b0;
            end else begin
                r_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.act.ratio <= RATIO_W'(INT_LO);
            r_q.len       <= RATIO_W'(INT_LO);
        end else begin
            r_q <= r_d;
        end
    end

    assign div_pulse = r_q.pulse;
    assign cfg_err   = r_q.err;
endmodule

// File: rtl/fbdiv_checker.sv
`timescale 1ns/1ps
module fbdiv_checker import fbdiv_pkg::*; #(
    parameter int unsigned INT_LO  = 2,
    parameter int unsigned INT_HI  = 66,
    parameter int unsigned FRAC_LO = 8,
    parameter int unsigned FRAC_HI = 66
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frac_mode,
    input logic [RATIO_W-1:0] ratio,
    input logic               load,
    input logic               div_pulse,
    input logic               cfg_err,
    input logic [RATIO_W-1:0] cnt,
    input logic [RATIO_W-1:0] len
);
    localparam int unsigned TOP_HI  = (INT_HI > FRAC_HI) ? INT_HI : FRAC_HI;
    localparam logic [7:0]  GAP_MIN = 8'(INT_LO);
    localparam logic [7:0]  GAP_MAX = 8'(TOP_HI + 1);
    localparam logic [RATIO_W-1:0] LEN_MIN = RATIO_W'(INT_LO);
    localparam logic [RATIO_W-1:0] LEN_MAX = RATIO_W'(TOP_HI + 1);

    logic       ok_ratio;
    logic [7:0] gap_q;
    logic       seen_q;

    always_comb begin
        if (frac_mode) ok_ratio = (int'(ratio) >= int'(FRAC_LO)) && (int'(ratio) <= int'(FRAC_HI));
        else           ok_ratio = (int'(ratio) >= int'(INT_LO))  && (int'(ratio) <= int'(INT_HI));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (div_pulse) begin
            gap_q  <= 8'd1;
            seen_q <= 1'b1;
        end else if (gap_q != 8'hFF) begin
            gap_q  <= gap_q + 8'd1;
        end
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) div_pulse |=> !div_pulse); // R9
    AST_ERR_ON_BAD_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (load && !ok_ratio) |=> cfg_err); // R5
    AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rst_n) !load |=> $stable(cfg_err)); // R5
    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) (load && ok_ratio) |=> !cfg_err); // R6
    AST_COUNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) cnt < len); // R7
    AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (len >= LEN_MIN) && (len <= LEN_MAX)); // R1
    AST_GAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (div_pulse && seen_q) |-> ((gap_q >= GAP_MIN) && (gap_q <= GAP_MAX))); // R2
endmodule

bind fb_clock_divider fbdiv_checker #(
    .INT_LO(INT_LO), .INT_HI(INT_HI), .FRAC_LO(FRAC_LO), .FRAC_HI(FRAC_HI)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frac_mode(frac_mode),
    .ratio    (ratio),
    .load     (load),
    .div_pulse(div_pulse),
    .cfg_err  (cfg_err),
    .cnt      (r_q.cnt),
    .len      (r_q.len)
);

// File: tb/fb_clock_divider_test.sv
`timescale 1ns/1ps
module fb_clock_divider_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frac_mode = 1'b0;
    logic [6:0]  ratio = '0;
    logic [15:0] frac = '0;
    logic        load = 1'b0;
    logic        div_pulse;
    logic        cfg_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model of the setting in use
    bit m_frac = 1'b0;
    int m_n = 2;
    int m_f = 0;
    int m_acc = 0;
    int exp_cur = 0;

    always #2.5 clk = ~clk;

    fb_clock_divider uut (
        .clk(clk), .rst_n(rst_n), .frac_mode(frac_mode), .ratio(ratio),
        .frac(frac), .load(load), .div_pulse(div_pulse), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int step();
        int s;
        if (m_frac) begin
            s = m_acc + m_f;
            m_acc = s & 32'hFFFF;
            return m_n + (s >> 16);
        end
        m_acc = 0;
        return m_n;
    endfunction

    // call on a falling edge where div_pulse is high
    task automatic measure(output int n);
        n = 0;
        @(negedge clk);
        n++;
        load = 1'b0;
        check(div_pulse == 1'b0, "R9", int'(div_pulse), 0);
        while (!div_pulse && n < 300) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_periods(input int k, input string tag, output int total);
        int n;
        total = 0;
        for (int i = 0; i < k; i++) begin
            measure(n);
            check(n == exp_cur, tag, n, exp_cur);
            total += n;
            exp_cur = step();
        end
    endtask

    task automatic do_load(input bit md, input int n, input int f, input bit legal, input string tag);
        int got;
        frac_mode = md;
        ratio = 7'(n);
        frac = 16'(f);
        load = 1'b1;
        measure(got);
        check(got == exp_cur, "R7", got, exp_cur);
        check(cfg_err == !legal, tag, int'(cfg_err), int'(!legal));
        if (legal) begin
            m_frac = md;
            m_n = n;
            m_f = f;
            m_acc = 0;
        end
        exp_cur = step();
    endtask

    initial begin
        #750000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        int tot;
        int fr [7] = '{0, 1, 16'h4000, 16'h8000, 16'hC000, 16'hFFFF, 16'h1234};
        int fn [5] = '{8, 9, 20, 65, 66};
        int bad_i [4] = '{0, 1, 67, 127};
        int bad_f [4] = '{7, 2, 67, 0};

        repeat (4) @(negedge clk);
        check(div_pulse == 1'b0, "R8", int'(div_pulse), 0);
        check(cfg_err == 1'b0, "R8", int'(cfg_err), 0);
        rst_n = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!div_pulse && n < 50);
        check(n == 2, "R8", n, 2);
        exp_cur = step();
        run_periods(3, "R8", tot);

        // every legal integer ratio
        for (int r = 2; r <= 66; r++) begin
            do_load(1'b0, r, 0, 1'b1, "R1");
            run_periods(2, "R1", tot);
        end

        // fraction word ignored in integer mode
        do_load(1'b0, 13, 16'hFFFF, 1'b1, "R10");
        run_periods(6, "R10", tot);
        check(tot == 78, "R10", tot, 78);

        // fractional grid
        foreach (fn[i]) begin
            foreach (fr[j]) begin
                do_load(1'b1, fn[i], fr[j], 1'b1, "R2");
                run_periods(24, (fr[j] == 0) ? "R4" : "R3", tot);
                if (fr[j] == 0)
                    check(tot == 24 * fn[i], "R4", tot, 24 * fn[i]);
                else
                    check(tot == 24 * fn[i] + (24 * fr[j]) / 65536, "R3", tot,
                          24 * fn[i] + (24 * fr[j]) / 65536);
            end
        end

        // illegal settings keep the running one
        do_load(1'b0, 10, 0, 1'b1, "R6");
        foreach (bad_i[i]) begin
            do_load(1'b0, bad_i[i], 0, 1'b0, "R5");
            run_periods(2, "R5", tot);
            check(cfg_err == 1'b1, "R5", int'(cfg_err), 1);
        end
        foreach (bad_f[i]) begin
            do_load(1'b1, bad_f[i], 16'h8000, 1'b0, "R5");
            run_periods(2, "R5", tot);
        end
        do_load(1'b1, 8, 16'h8000, 1'b1, "R6");
        run_periods(8, "R6", tot);
        check(tot == 68, "R3", tot, 68);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule